// File: doc/BRIEF.md
# Interval Timer with Count Snapshot

This block is a 32-bit down-counting interval timer that software drives through a small word-addressed register bus with 16-bit data. The period is written as two 16-bit halves. Strobe bits in the control word start and stop the timer, and a stored mode bit selects one-shot or continuous reload. The timer counts one tick per clock cycle. One full interval lasts period+1 ticks. When the count runs out, a sticky timeout flag is set and the period is loaded again. In one-shot mode the timer then stops with the counter parked at the period value.

Software can freeze the live count into two snapshot registers by writing either snapshot address. A level interrupt output is high while the timeout flag and the interrupt-enable bit are both set. Reads go through a registered read-data port: the data and a one-cycle valid pulse appear in the cycle after the read strobe. The bus has no back-pressure. Every read and write strobe is accepted in the cycle it is presented, so no ready signal exists.

Word offsets: 0 status, 1 control, 2 period low half, 3 period high half, 4 snapshot low half, 5 snapshot high half.

Top module: `ivt_timer_top`

## Requirements
- R1: After reset, the status, control, period and snapshot registers read zero and `irq_o` is low. The internal count is all ones: a snapshot taken before any period write reads 0xFFFF in both halves.
- R2: Reads of offsets 6 and 7 return zero. A status read returns the timeout flag in bit 0 and the running flag in bit 1. A control read returns the interrupt enable in bit 0 and continuous mode in bit 1. All other read bits are zero.
- R3: A read strobe in one cycle makes `rd_valid` high in the next cycle. `rdata` then carries the register value as it stood when the strobe was sampled. Without a strobe, `rd_valid` is low and `rdata` is zero.
- R4: Any write to offset 0 clears the timeout flag, whatever the data, and leaves the running flag unchanged. If the count expires in the same cycle, the flag stays set.
- R5: A control write stores bit 0 (interrupt enable) and bit 1 (continuous mode). Bit 2 is a start strobe and bit 3 is a stop strobe, and neither is stored. Start takes effect only when the timer is idle, and stop only when it is running. With both set, start is applied first and then stop, so the timer ends up stopped.
- R6: A write to offset 2 or 3 stores that half of the period. It stops the timer and loads the count with the new 32-bit period {high, low}.
- R7: While running, the count decreases by one per cycle. From count P, the timeout flag is set on the P+1th clock edge after the start strobe is written, and the count is reloaded with the period.
- R8: On expiry in continuous mode the timer keeps running. In one-shot mode the running flag clears and the count stays at the period value.
- R9: A write to offset 4 or 5 copies the count held in that cycle into both snapshot halves: low 16 bits to offset 4 and high 16 bits to offset 5.
- R10: `irq_o` equals the timeout flag AND the interrupt enable. It changes in the same cycle as whichever of the two changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one timer tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rdata | output | 16 | Registered read data, zero when not valid |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that `wr_en`, `rd_en`, `addr` and `wdata` are known and change only away from the rising edge. A read and a write may share a cycle: the read then returns the value before the write. Periods stay small in the stimulus so that expiry, reload and their collisions with bus writes happen often. The random phase keeps the high period half at zero. The directed sequences place a status write exactly on an expiry edge and both strobes in one control word.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // word offsets decoded by the register block
  localparam int OFS_STATUS  = 0;
  localparam int OFS_CTRL    = 1;
  localparam int OFS_PERIOD0 = 2;
  localparam int OFS_SNAP0   = 4;
  // field positions
  localparam int BIT_TO      = 0;
  localparam int BIT_RUN     = 1;
  localparam int BIT_IEN     = 0;
  localparam int BIT_CONT    = 1;
  localparam int BIT_START   = 2;
  localparam int BIT_STOP    = 3;

  typedef struct packed {
    logic cont;
    logic ien;
  } ivt_cfg_t;
endpackage

// File: rtl/ivt_core.sv
module ivt_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cont,
  input  logic [CNT_W-1:0] period_q,
  input  logic [CNT_W-1:0] period_nx,
  input  logic             per_wr,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             status_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             to_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic             run_d;
  logic             to_d;

  assign expire = run_q && (cnt_q == '0);

  always_comb begin
    // expiry and counting act first, bus writes then apply on top
    cnt_d = cnt_q;
    run_d = run_q;
    if (run_q) begin
      if (expire) begin
        cnt_d = period_q;
        if (!cfg_cont) run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (start_req && !run_d) run_d = 1'b1;
    if (stop_req && run_d)   run_d = 1'b0;
    if (per_wr) begin
      run_d = 1'b0;
      cnt_d = period_nx;
    end
  end

  always_comb begin
    to_d = to_q;
    if (expire)          to_d = 1'b1;
    else if (status_clr) to_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
      run_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      to_q  <= to_d;
    end
  end
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run_q,
  input  logic              to_q,
  input  logic [CNT_W-1:0]  cnt_q,
  output ivt_cfg_t          cfg_q,
  output logic [CNT_W-1:0]  period_q,
  output logic [CNT_W-1:0]  period_nx,
  output logic [CNT_W-1:0]  snap_q,
  output logic              per_wr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata
);
  localparam int NHALF = CNT_W / DATA_W;

  logic [NHALF-1:0]  per_hit;
  logic              snap_wr;
  logic              ctrl_wr;
  logic [DATA_W-1:0] rd_word;

  assign ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign snap_wr = wr_en && (int'(addr) >= OFS_SNAP0) && (int'(addr) < OFS_SNAP0 + NHALF);
  assign per_wr  = |per_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= '0;
    else if (ctrl_wr) cfg_q <= '{cont: wdata[BIT_CONT], ien: wdata[BIT_IEN]};
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [DATA_W-1:0] per_r;
    logic [DATA_W-1:0] snap_r;

    assign per_hit[h] = wr_en && (addr == ADDR_W'(OFS_PERIOD0 + h));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        per_r  <= '0;
        snap_r <= '0;
      end else begin
        if (per_hit[h]) per_r  <= wdata;
        if (snap_wr)    snap_r <= cnt_q[h*DATA_W +: DATA_W];
      end
    end

    assign period_q[h*DATA_W +: DATA_W]  = per_r;
    assign period_nx[h*DATA_W +: DATA_W] = per_hit[h] ? wdata : per_r;
    assign snap_q[h*DATA_W +: DATA_W]    = snap_r;
  end

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(OFS_STATUS)) begin
      rd_word[BIT_TO]  = to_q;
      rd_word[BIT_RUN] = run_q;
    end
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rd_word[BIT_IEN]  = cfg_q.ien;
      rd_word[BIT_CONT] = cfg_q.cont;
    end
    for (int h = 0; h < NHALF; h++) begin
      if (addr == ADDR_W'(OFS_PERIOD0 + h)) rd_word = period_q[h*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OFS_SNAP0 + h))   rd_word = snap_q[h*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? rd_word : '0;
    end
  end
endmodule

// File: rtl/ivt_timer_top.sv
module ivt_timer_top
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  ivt_cfg_t         cfg_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] period_nx;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] cnt_q;
  logic             per_wr;
  logic             run_q;
  logic             to_q;
  logic             expire;
  logic             status_clr;
  logic             start_req;
  logic             stop_req;

  assign status_clr = wr_en && (addr == ADDR_W'(OFS_STATUS));
  assign start_req  = wr_en && (addr == ADDR_W'(OFS_CTRL)) && wdata[BIT_START];
  assign stop_req   = wr_en && (addr == ADDR_W'(OFS_CTRL)) && wdata[BIT_STOP];

  ivt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .run_q(run_q), .to_q(to_q), .cnt_q(cnt_q), .cfg_q(cfg_q),
    .period_q(period_q), .period_nx(period_nx), .snap_q(snap_q),
    .per_wr(per_wr), .rd_valid(rd_valid), .rdata(rdata)
  );

  ivt_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_q.cont), .period_q(period_q),
    .period_nx(period_nx), .per_wr(per_wr), .start_req(start_req),
    .stop_req(stop_req), .status_clr(status_clr), .cnt_q(cnt_q),
    .run_q(run_q), .to_q(to_q), .expire(expire)
  );

  assign irq_o = to_q & cfg_q.ien;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_o,
  input logic              ien_q,
  input logic              cont_q,
  input logic              status_clr,
  input logic              start_req,
  input logic              stop_req,
  input logic              per_wr,
  input logic              snap_wr,
  input logic              expire,
  input logic              run_q,
  input logic              to_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  period_q,
  input logic [CNT_W-1:0]  period_nx,
  input logic [CNT_W-1:0]  snap_q
);
  assert_rd_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rdata == '0));
  assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !expire) |=> !to_q);
  assert_timeout_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> to_q);
  assert_both_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && stop_req) |=> !run_q);
  assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !stop_req && !run_q && !per_wr) |=> run_q);
  assert_period_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |=> (!run_q && cnt_q == $past(period_nx)));
  assert_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !expire && !per_wr) |=> cnt_q == $past(cnt_q - 1'b1));
  assert_oneshot_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cont_q && !per_wr && !start_req) |=> (!run_q && cnt_q == $past(period_q)));
  assert_continuous_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cont_q && !per_wr && !stop_req) |=> run_q);
  assert_snapshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |=> snap_q == $past(cnt_q));
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> !irq_o);
endmodule

bind ivt_timer_top ivt_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid), .rdata(rdata),
  .irq_o(irq_o), .ien_q(cfg_q.ien), .cont_q(cfg_q.cont), .status_clr(status_clr),
  .start_req(start_req), .stop_req(stop_req), .per_wr(per_wr),
  .snap_wr(regs_i.snap_wr), .expire(expire), .run_q(run_q), .to_q(to_q),
  .cnt_q(cnt_q), .period_q(period_q), .period_nx(period_nx), .snap_q(snap_q)
);

// File: tb/ivt_timer_tb.sv
module ivt_timer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        rd_valid;
  logic [15:0] rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ivt_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata), .irq_o(irq_o)
  );

  // behavioural reference state
  bit          m_to, m_run, m_ien, m_cont, m_rv;
  logic [15:0] m_plo, m_phi, m_slo, m_shi, m_rd;
  logic [31:0] m_cnt;

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0:    return {14'd0, m_run, m_to};
      3'd1:    return {14'd0, m_cont, m_ien};
      3'd2:    return m_plo;
      3'd3:    return m_phi;
      3'd4:    return m_slo;
      3'd5:    return m_shi;
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_to = 0; m_run = 0; m_ien = 0; m_cont = 0; m_rv = 0;
      m_plo = 0; m_phi = 0; m_slo = 0; m_shi = 0; m_rd = 0;
      m_cnt = 32'hFFFF_FFFF;
    end else begin
      bit          hit;
      bit          nrun;
      logic [31:0] ncnt;
      m_rv = rd_en;
      m_rd = rd_en ? m_read(addr) : 16'd0;
      hit  = m_run && (m_cnt == 0);
      nrun = m_run;
      ncnt = m_cnt;
      if (m_run) begin
        if (hit) begin
          ncnt = {m_phi, m_plo};
          m_to = 1;
          if (!m_cont) nrun = 0;
        end else ncnt = m_cnt - 1;
      end
      if (wr_en) begin
        case (addr)
          3'd0: if (!hit) m_to = 0;
          3'd1: begin
            m_ien = wdata[0]; m_cont = wdata[1];
            if (wdata[2] && !nrun) nrun = 1;
            if (wdata[3] && nrun) nrun = 0;
          end
          3'd2: begin m_plo = wdata; nrun = 0; ncnt = {m_phi, wdata}; end
          3'd3: begin m_phi = wdata; nrun = 0; ncnt = {wdata, m_plo}; end
          3'd4, 3'd5: begin m_slo = m_cnt[15:0]; m_shi = m_cnt[31:16]; end
          default: ;
        endcase
      end
      m_run = nrun;
      m_cnt = ncnt;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the reference every cycle (R3 read port, R10 interrupt)
  always @(negedge clk) begin
    if (model_on) begin
      check("R3 rd_valid vs model", {31'd0, rd_valid}, {31'd0, m_rv});
      check("R3 rdata vs model", {16'd0, rdata}, {16'd0, m_rd});
      check("R10 irq vs model", {31'd0, irq_o}, {31'd0, (m_to && m_ien)});
    end
  end

  // tasks are entered at a falling edge and return at the next one
  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_rd(a, d);
    check(tag, {16'd0, d}, {16'd0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;

    // R1 reset state
    check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    rd_check("R1 status reset", 3'd0, 16'h0000);
    rd_check("R1 control reset", 3'd1, 16'h0000);
    rd_check("R1 period low reset", 3'd2, 16'h0000);
    rd_check("R1 period high reset", 3'd3, 16'h0000);
    rd_check("R1 snapshot reset", 3'd4, 16'h0000);
    bus_wr(3'd5, 16'h0000);
    rd_check("R9 snapshot low of reset count", 3'd4, 16'hFFFF);
    rd_check("R9 snapshot high of reset count", 3'd5, 16'hFFFF);
    // R2 unmapped offsets
    rd_check("R2 offset 6 reads zero", 3'd6, 16'h0000);
    rd_check("R2 offset 7 reads zero", 3'd7, 16'h0000);

    // one-shot run, period 5, interrupt enabled
    bus_wr(3'd2, 16'd5);
    bus_wr(3'd3, 16'd0);
    bus_wr(3'd1, 16'h0005);
    rd_check("R5 strobes not stored", 3'd1, 16'h0001);
    rd_check("R5 start sets running", 3'd0, 16'h0002);
    idle(10);
    rd_check("R8 one-shot expiry: timeout set, idle", 3'd0, 16'h0001);
    check("R10 irq with timeout and enable", {31'd0, irq_o}, 32'd1);
    bus_wr(3'd4, 16'h0000);
    rd_check("R8 count parked at period", 3'd4, 16'd5);
    bus_wr(3'd0, 16'h1234);
    rd_check("R4 status write clears timeout", 3'd0, 16'h0000);
    check("R10 irq low after clear", {31'd0, irq_o}, 32'd0);

    // R5 both strobes from idle
    bus_wr(3'd1, 16'h000C);
    rd_check("R5 start+stop from idle ends stopped", 3'd0, 16'h0000);
    // R8 continuous
    bus_wr(3'd1, 16'h0007);
    idle(20);
    rd_check("R8 continuous keeps running", 3'd0, 16'h0003);
    rd_check("R2 control read bits", 3'd1, 16'h0003);
    bus_wr(3'd1, 16'h000F);
    rd_check("R5 start+stop while running ends stopped", 3'd0, 16'h0001);

    // R6 period write halts
    bus_wr(3'd1, 16'h0006);
    idle(2);
    bus_wr(3'd3, 16'h0001);
    rd_check("R6 period write clears running", 3'd0, 16'h0001);
    bus_wr(3'd4, 16'h0000);
    rd_check("R6 count loaded low", 3'd4, 16'd5);
    rd_check("R6 count loaded high", 3'd5, 16'd1);
    bus_wr(3'd3, 16'h0000);

    // R7 exact interval with period 3
    bus_wr(3'd2, 16'd3);
    bus_wr(3'd0, 16'h0000);
    bus_wr(3'd1, 16'h0005);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R7 timeout on edge period+1", {31'd0, irq_o}, {31'd0, (i == 4)});
    end

    // R4 timeout wins over a status write on the expiry edge
    bus_wr(3'd0, 16'h0000);
    bus_wr(3'd1, 16'h0007);
    idle(7);
    bus_wr(3'd0, 16'hFFFF);
    check("R4 expiry beats status write", {31'd0, irq_o}, 32'd1);
    bus_wr(3'd0, 16'h0000);
    check("R4 later status write clears", {31'd0, irq_o}, 32'd0);
    bus_wr(3'd1, 16'h0008);

    // mixed traffic, checked against the reference every cycle
    for (int k = 0; k < 6000; k++) begin
      logic [2:0] a;
      a     = 3'($urandom % 8);
      wr_en = (($urandom % 4) == 0);
      rd_en = (($urandom % 2) == 0);
      addr  = a;
      case (a)
        3'd2:    wdata = 16'($urandom % 24);
        3'd3:    wdata = 16'h0000;
        default: wdata = 16'($urandom);
      endcase
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    idle(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule